// File: doc/BRIEF.md
# Noise-Shaped Fractional-N Clock Divider

This block divides an input clock by a ratio that may include a fraction. In each output period it counts down a divisor equal to an integer base plus a small signed offset, and it emits a one-cycle pulse when that period ends. A cascade of two error-feedback accumulators produces the offset. That offset decides how far each period departs from the base ratio. The long-run mean of the divisor is the base plus the fractional word divided by 2^16. The excursions do not repeat in a short fixed rhythm. Their spectrum is pushed toward high frequencies, so a loop filter downstream can remove them. The block sits in the feedback path of a synthesizer, between the oscillator output and the phase comparator.

Control is a two-state machine. ST_IDLE holds the down-counter at zero and produces no pulses. When `en` is high, the edge that sees it moves the machine to ST_COUNT. The same edge loads the first divisor and advances the modulator once. In ST_COUNT the counter decrements on every edge. The edge that sees a count of 1 is the period boundary. On that edge the machine raises the pulse, loads the next divisor and advances the modulator. Dropping `en` sends ST_COUNT back to ST_IDLE on the next edge and abandons the period in progress. The accumulators keep their contents while idle.

Top module: `fnd_divider`

## Requirements
- R1: While `rst` is high at a rising edge, the block enters ST_IDLE and drives `div_pulse_o`=0, `mod_sel_o`=0 and `ofs_o`=0. Both accumulators and the held second-stage carry are cleared.
- R2: Each period lasts exactly D = Neff + offset input clocks, where the offset is the value `ofs_o` shows during that period. `div_pulse_o` marks the end of each period and is high for exactly one clock.
- R3: The offset comes from this per-step update, with F = `frac` and all sums taken modulo 2^16. First a1' = a1 + F, with carry c1. Then a2' = a2 + a1', with carry c2. The offset is y = c1 + c2 − c2prev, and the register c2prev then takes the value c2. `ofs_o` shows y as 3-bit two's complement (range −1 to +2). It updates on the enable edge and on every edge that raises `div_pulse_o`.
- R4: `mod_sel_o` shows c1 of the current period. A 1 means the first stage chose N+1. Starting from reset with F a multiple of 2^(16−k), any 2^k consecutive periods contain exactly F/2^(16−k) periods with `mod_sel_o`=1.
- R5: The modulator advances exactly once per period boundary and once on each enable edge, and at no other time.
- R6: `n_div` and `frac` are used only on the edge that loads a divisor. A change in mid-period leaves the length of the running period unchanged.
- R7: When `frac` is 0 from reset, every offset is 0 and every period lasts exactly Neff clocks.
- R8: Neff equals `n_div`, except that a value below 4 is treated as 4. The divisor therefore ranges from 3 to 257.
- R9: When `en` is low at an edge, the next state is ST_IDLE, no pulse follows, and `ofs_o` and the accumulator state are held. On re-enable, a new period starts with the next modulator step. Its pulse appears D clocks after the enable edge.
- R10: Counted from reset, the total number of input clocks over P complete periods equals Neff·P plus the number of those periods with `mod_sel_o`=1, plus 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable |
| n_div | input | 8 | Integer base ratio |
| frac | input | 16 | Fractional word, in units of 2^-16 |
| div_pulse_o | output | 1 | One-clock pulse at the end of each period |
| mod_sel_o | output | 1 | First-stage N+1 choice for the current period |
| ofs_o | output | 3 | Signed offset for the current period |

## Verification
The bench runs a step-by-step model of the accumulator cascade. Every measured gap must match the base plus the modelled offset. This catches a carry taken from the wrong stage or a dropped c2prev term, because those would produce periods of the wrong length. The bench checks the corners that are easy to get wrong. It runs the smallest base with a −1 offset, to catch a divisor of 3 being mishandled. It runs the largest base with a +2 offset, to catch a 257 count truncated to 8 bits. It drives a sub-minimum `n_div` that must be clamped, and it changes the ratio mid-period, which a design that reads inputs every clock would apply too early. It disables and re-enables the block, which exposes a modulator that advances during idle or restarts from zero. It also counts N+1 choices over power-of-two windows, so an accumulator with a wrong width or a wrong carry shows up as a wrong count.

// File: rtl/fnd_pkg.sv
package fnd_pkg;

    // Control state of the period counter
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } fnd_state_e;

    // Number of cascaded accumulator stages in the modulator
    localparam int MASH_STAGES = 2;

    // Width of the signed offset (range -1 .. +2)
    localparam int OFS_W = 3;

endpackage

// File: rtl/fnd_accum.sv
module fnd_accum #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic [W-1:0] addend,
    output logic [W-1:0] sum_next,
    output logic         carry
);

    logic [W-1:0] acc_q;
    logic [W:0]   full_sum;

    // Wide sum so the carry out of the stage is explicit
    assign full_sum = {1'b0, acc_q} + {1'b0, addend};
    assign sum_next = full_sum[W-1:0];
    assign carry    = full_sum[W];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= sum_next;
        end
    end

    // The residue only moves on a period boundary or an enable edge
    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst) !step |=> $stable(acc_q)); // R5

endmodule

// File: rtl/fnd_mash.sv
module fnd_mash
    import fnd_pkg::*;
#(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [W-1:0]     frac_i,
    output logic [OFS_W-1:0] ofs_next,
    output logic             sel_next
);

    logic [MASH_STAGES-1:0][W-1:0] stage_in;
    logic [MASH_STAGES-1:0][W-1:0] stage_sum;
    logic [MASH_STAGES-1:0]        stage_cy;
    logic                          c2_prev_q;

    // Stage 0 integrates the fractional word, each later stage the residue of the one before
    for (genvar g = 0; g < MASH_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign stage_in[g] = frac_i;
        end else begin : g_next
            assign stage_in[g] = stage_sum[g-1];
        end
        fnd_accum #(.W(W)) u_acc (
            .clk      (clk),
            .rst      (rst),
            .step     (step),
            .addend   (stage_in[g]),
            .sum_next (stage_sum[g]),
            .carry    (stage_cy[g])
        );
    end

    // Second-order noise-shaped offset: c1 + c2 - c2[n-1], two's complement
    assign ofs_next = {2'b00, stage_cy[0]} + {2'b00, stage_cy[1]} - {2'b00, c2_prev_q};
    assign sel_next = stage_cy[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            c2_prev_q <= 1'b0;
        end else if (step) begin
            c2_prev_q <= stage_cy[1];
        end
    end

    AST_C2_HOLD: assert property (@(posedge clk) disable iff (rst) !step |=> $stable(c2_prev_q)); // R5

endmodule

// File: rtl/fnd_ctrl.sv
module fnd_ctrl
    import fnd_pkg::*;
#(
    parameter int NW    = 8,
    parameter int N_MIN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic [NW-1:0]    n_eff_i,
    input  logic [OFS_W-1:0] ofs_next_i,
    input  logic             sel_next_i,
    output logic             step_o,
    output logic             pulse_o,
    output logic [OFS_W-1:0] ofs_o,
    output logic             sel_o
);

    // Count width holds the largest base plus the largest offset
    localparam int CW = NW + 1;

    fnd_state_e       st_q, st_d;
    logic [CW-1:0]    cnt_q;
    logic [CW-1:0]    divisor;
    logic             term;
    logic             pulse_q;
    logic [OFS_W-1:0] ofs_q;
    logic             sel_q;

    assign divisor = {1'b0, n_eff_i} + {{(CW-OFS_W){ofs_next_i[OFS_W-1]}}, ofs_next_i};
    assign term    = (st_q == ST_COUNT) && (cnt_q == CW'(1));
    assign step_o  = en_i && ((st_q == ST_IDLE) || term);

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (en_i)  st_d = ST_COUNT;
            ST_COUNT: if (!en_i) st_d = ST_IDLE;
            default:             st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Counter and registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
            ofs_q   <= '0;
            sel_q   <= 1'b0;
        end else begin
            pulse_q <= en_i && term;
            if (!en_i) begin
                cnt_q <= '0;
            end else if (step_o) begin
                cnt_q <= divisor;
                ofs_q <= ofs_next_i;
                sel_q <= sel_next_i;
            end else begin
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end

    assign pulse_o = pulse_q;
    assign ofs_o   = ofs_q;
    assign sel_o   = sel_q;

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) pulse_q |=> !pulse_q); // R2
    AST_COUNT_LIVE: assert property (@(posedge clk) disable iff (rst) (st_q == ST_COUNT) |-> (cnt_q != '0)); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !en_i |=> (!pulse_q && st_q == ST_IDLE)); // R9
    AST_RELOAD_RANGE: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> (cnt_q >= CW'(N_MIN - 1) && cnt_q <= {1'b0, $past(n_eff_i)} + CW'(2))); // R8

endmodule

// File: rtl/fnd_divider.sv
module fnd_divider
    import fnd_pkg::*;
#(
    parameter int N_W   = 8,
    parameter int F_W   = 16,
    parameter int N_MIN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [N_W-1:0]   n_div,
    input  logic [F_W-1:0]   frac,
    output logic             div_pulse_o,
    output logic             mod_sel_o,
    output logic [OFS_W-1:0] ofs_o
);

    logic [N_W-1:0]   n_eff;
    logic             step;
    logic [OFS_W-1:0] ofs_next;
    logic             sel_next;

    // Bases below the legal minimum are raised to it
    assign n_eff = (n_div < N_W'(N_MIN)) ? N_W'(N_MIN) : n_div;

    fnd_mash #(.W(F_W)) u_mash (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .frac_i   (frac),
        .ofs_next (ofs_next),
        .sel_next (sel_next)
    );

    fnd_ctrl #(.NW(N_W), .N_MIN(N_MIN)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .en_i       (en),
        .n_eff_i    (n_eff),
        .ofs_next_i (ofs_next),
        .sel_next_i (sel_next),
        .step_o     (step),
        .pulse_o    (div_pulse_o),
        .ofs_o      (ofs_o),
        .sel_o      (mod_sel_o)
    );

endmodule

// File: tb/fnd_divider_bench.sv
`timescale 1ns/1ps
module fnd_divider_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [7:0]  n_div = 8'd6;
    logic [15:0] frac = 16'h0;
    logic        div_pulse_o;
    logic        mod_sel_o;
    logic [2:0]  ofs_o;

    always #2.5 clk = ~clk;

    fnd_divider u_fnd_divider (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .n_div       (n_div),
        .frac        (frac),
        .div_pulse_o (div_pulse_o),
        .mod_sel_o   (mod_sel_o),
        .ofs_o       (ofs_o)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // Independent model of the accumulator cascade, per R3
    logic [15:0] m_a1, m_a2;
    logic        m_c2p;

    // Vector table: {base, fractional word, periods}
    localparam logic [39:0] VECS [7] = '{
        {8'd6,   16'h0000, 16'd20},
        {8'd5,   16'h4000, 16'd24},
        {8'd8,   16'h8000, 16'd24},
        {8'd4,   16'h5555, 16'd40},
        {8'd12,  16'hC000, 16'd24},
        {8'd3,   16'h1000, 16'd20},
        {8'd255, 16'hFFFF, 16'd6}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        m_a1 = '0; m_a2 = '0; m_c2p = 1'b0;
    endtask

    task automatic model_step(input logic [15:0] f, output int y, output int c1);
        logic [16:0] s1, s2;
        s1 = {1'b0, m_a1} + {1'b0, f};
        s2 = {1'b0, m_a2} + {1'b0, s1[15:0]};
        y  = int'(s1[16]) + int'(s2[16]) - int'(m_c2p);
        c1 = int'(s1[16]);
        m_a1 = s1[15:0]; m_a2 = s2[15:0]; m_c2p = s2[16];
    endtask

    task automatic wait_pulse(output int cnt);
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (!div_pulse_o && cnt < 2000);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; en = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 pulse", int'(div_pulse_o), 0);
        check("R1 sel", int'(mod_sel_o), 0);
        check("R1 ofs", int'($signed(ofs_o)), 0);
        rst = 1'b0;
        model_clear();
    endtask

    // Enables at the current negedge and measures a run of periods
    task automatic run_seq(input int nv, input int fv, input int periods, output int sels);
        int neff, y, c1, gap, total, diff;
        string rq;
        neff  = (nv < 4) ? 4 : nv;
        total = 0;
        sels  = 0;
        rq    = (fv == 0) ? "R7" : "R3";
        n_div = nv[7:0]; frac = fv[15:0]; en = 1'b1;
        model_step(fv[15:0], y, c1);
        @(negedge clk);
        check(rq, int'($signed(ofs_o)), y);
        check("R4", int'(mod_sel_o), c1);
        for (int k = 0; k < periods; k++) begin
            wait_pulse(gap);
            check((nv < 4) ? "R8" : "R2", gap, neff + y);
            total += gap;
            sels  += c1;
            model_step(fv[15:0], y, c1);
            check(rq, int'($signed(ofs_o)), y);
            check("R4", int'(mod_sel_o), c1);
        end
        diff = total - neff * periods - sels;
        check("R10", (diff >= 0 && diff <= 1) ? diff : -99, (diff >= 0 && diff <= 1) ? diff : 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int sels, gap, y, c1, pulses, held;

        // Table-driven runs
        for (int v = 0; v < 7; v++) begin
            do_reset();
            run_seq(int'(VECS[v][39:32]), int'(VECS[v][31:16]), int'(VECS[v][15:0]), sels);
        end

        // R4: 1/8 fraction gives exactly 4 N+1 choices in 32 periods
        do_reset();
        run_seq(5, 16'h2000, 32, sels);
        check("R4 window", sels, 4);

        // R8: base of 0 behaves as 4
        do_reset();
        run_seq(0, 0, 3, sels);

        // R6: mid-period change waits for the boundary
        do_reset();
        run_seq(6, 0, 2, sels);
        @(negedge clk);
        n_div = 8'd9; frac = 16'h8000;
        wait_pulse(gap);
        check("R6 running period", gap + 1, 6);
        model_step(16'h8000, y, c1);
        check("R6 ofs", int'($signed(ofs_o)), y);
        wait_pulse(gap);
        check("R6 new base", gap, 9 + y);
        model_step(16'h8000, y, c1);
        wait_pulse(gap);
        check("R6 new fraction", gap, 9 + y);

        // R9/R5: disable, stay quiet, resume with the next modulator step
        do_reset();
        run_seq(5, 16'h4000, 3, sels);
        held = int'($signed(ofs_o));
        en = 1'b0;
        pulses = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (div_pulse_o) pulses++;
        end
        check("R9 no pulse", pulses, 0);
        check("R9 ofs held", int'($signed(ofs_o)), held);
        en = 1'b1;
        model_step(16'h4000, y, c1);
        @(negedge clk);
        check("R5 resume ofs", int'($signed(ofs_o)), y);
        check("R5 resume sel", int'(mod_sel_o), c1);
        wait_pulse(gap);
        check("R9 resume gap", gap, 5 + y);

        // R1: reset mid-run clears the modulator
        @(negedge clk);
        do_reset();
        run_seq(5, 16'h4000, 8, sels);
        check("R1 restart sels", sels, 2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule